// File: doc/BRIEF.md
# Instruction Prefix and ModRM Decoder

This block is the front end of an instruction decoder. It takes one instruction byte per clock on a valid/ready stream. Each instruction may open with operand-size or address-size prefix bytes, then carries an opcode byte and a ModRM byte, then zero to four displacement bytes. Every opcode that reaches this block is taken to be followed by a ModRM byte. Opcode meaning, immediates, scaled-index bytes and execution belong to later stages.

When the last byte of an instruction has been taken, the block presents one decoded record on a second valid/ready stream. The record holds:
- the 6-bit operation code, the direction bit and the width bit;
- the effective operand size and the effective address size;
- whether the instruction addresses a register or memory;
- the MOD, REG and R/M fields;
- the displacement, sign-extended to 32 bits.

Back-pressure works as follows. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. A record is handed over on an edge where `out_valid` and `out_ready` are both high. While a record waits, `in_ready` stays low, so upstream holds its bytes. The sender may leave gaps between bytes without changing the result. The `dflt_32` input gives the default size for operands and addresses, and must stay steady from the first byte of an instruction until its ModRM byte has been taken.

Top module: `ixd_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A prefix byte 66h makes the effective operand size the opposite of the default (`dflt_32`=1 means 32-bit). Any number of 66h bytes in one instruction toggle it only once.
- R3: A prefix byte 67h makes `out_addr32` the opposite of `dflt_32`. Repeats of 67h toggle it only once.
- R4: The opcode byte is split as follows. Bits 7:2 go to `out_opcode`, bit 1 to `out_dir` and bit 0 to `out_wide`. `out_op_size` is encoded 0 for byte, 1 for 16-bit and 2 for 32-bit. It reads 0 when the width bit is 0; otherwise it reads 1 or 2 from the effective operand size.
- R5: The ModRM byte is split as follows. Bits 7:6 go to `out_mod`, bits 5:3 to `out_reg` and bits 2:0 to `out_rm`. MOD=11 sets `out_reg_mode`, no displacement bytes follow, and `out_disp` is 0.
- R6: MOD=00 takes no displacement bytes and gives `out_disp`=0, with one exception. With 16-bit addressing and R/M=110, two displacement bytes follow.
- R7: MOD=01 takes one displacement byte, which is sign-extended to 32 bits.
- R8: MOD=10 takes two displacement bytes under 16-bit addressing, sign-extended, or four under 32-bit addressing. Displacement bytes arrive least significant first.
- R9: While `out_valid` is 1 and `out_ready` is 0, every record output holds steady and `in_ready` is 0, so no input byte is taken.
- R10: On the edge where a record is taken, `out_valid` falls and prefix state is cleared, so the next instruction starts from the default sizes.
- R11: `out_valid` rises on the clock edge that takes the last byte of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dflt_32 | input | 1 | Default size: 1 = 32-bit, 0 = 16-bit |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 6 | Operation code field |
| out_dir | output | 1 | Direction bit |
| out_wide | output | 1 | Width bit |
| out_op_size | output | 2 | Effective operand size (0 byte, 1 16-bit, 2 32-bit) |
| out_addr32 | output | 1 | Effective address size is 32-bit |
| out_reg_mode | output | 1 | Register mode (MOD=11) |
| out_mod | output | 2 | MOD field |
| out_reg | output | 3 | REG field |
| out_rm | output | 3 | R/M field |
| out_disp | output | 32 | Sign-extended displacement |

## Verification
The displacement count is the most fragile piece of state. If it is wrong, the decoder takes a displacement byte as the next opcode, or takes an opcode as displacement. That shows at the ports within one instruction: a record arrives a byte early or a byte late (R11), or the next record has the wrong fields. A prefix flag that survives into the next instruction shows as a wrong operand or address size on the very next record. A broken hold path shows as changed record fields, or as a byte taken, while `out_ready` is low.

// File: rtl/ixd_pkg.sv
package ixd_pkg;
  localparam int DISP_BYTES = 4;
  localparam int DISP_W     = DISP_BYTES * 8;
  localparam int LANE_W     = $clog2(DISP_BYTES);
  localparam int LEN_W      = $clog2(DISP_BYTES + 1);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } op_size_e;

  typedef enum logic [1:0] {
    ST_LEAD  = 2'd0,
    ST_MODRM = 2'd1,
    ST_DISP  = 2'd2,
    ST_HOLD  = 2'd3
  } dec_state_e;
endpackage

// File: rtl/ixd_prefix_track.sv
module ixd_prefix_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit_op,
  input  logic hit_ad,
  input  logic dflt_32,
  output logic op32_eff,
  output logic ad32_eff
);
  logic op_seen, ad_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      op_seen <= 1'b0;
      ad_seen <= 1'b0;
    end else begin
      if (hit_op) op_seen <= 1'b1;
      if (hit_ad) ad_seen <= 1'b1;
    end
  end

  assign op32_eff = dflt_32 ^ op_seen;
  assign ad32_eff = dflt_32 ^ ad_seen;
endmodule

// File: rtl/ixd_disp_len.sv
module ixd_disp_len
  import ixd_pkg::*;
(
  input  logic [1:0]       mod_f,
  input  logic [2:0]       rm_f,
  input  logic             addr32,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    unique case (mod_f)
      2'b00:   len = (!addr32 && rm_f == 3'b110) ? LEN_W'(2) : LEN_W'(0);
      2'b01:   len = LEN_W'(1);
      2'b10:   len = addr32 ? LEN_W'(4) : LEN_W'(2);
      default: len = LEN_W'(0);
    endcase
  end
endmodule

// File: rtl/ixd_disp_collect.sv
module ixd_disp_collect
  import ixd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  input  logic [LEN_W-1:0]  len,
  output logic [DISP_W-1:0] disp
);
  logic [DISP_W-1:0] raw;

  for (genvar b = 0; b < DISP_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        raw[b*8 +: 8] <= 8'h00;
      else if (wr && lane == LANE_W'(b))
        raw[b*8 +: 8] <= byte_in;
    end
  end

  logic sgn;
  always_comb begin
    sgn = 1'b0;
    for (int k = 1; k <= DISP_BYTES; k++)
      if (len == LEN_W'(k)) sgn = raw[k*8-1];
    for (int i = 0; i < DISP_W; i++)
      disp[i] = (i < int'(len) * 8) ? raw[i] : sgn;
  end
endmodule

// File: rtl/ixd_decoder.sv
module ixd_decoder
  import ixd_pkg::*;
#(
  parameter logic [7:0] PFX_OPSZ = 8'h66,
  parameter logic [7:0] PFX_ADSZ = 8'h67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dflt_32,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [5:0]        out_opcode,
  output logic              out_dir,
  output logic              out_wide,
  output logic [1:0]        out_op_size,
  output logic              out_addr32,
  output logic              out_reg_mode,
  output logic [1:0]        out_mod,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_rm,
  output logic [DISP_W-1:0] out_disp
);
  dec_state_e        state;
  logic [LANE_W-1:0] cnt;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              take, done, op32_eff, ad32_eff, hit_op, hit_ad;

  assign in_ready  = (state != ST_HOLD);
  assign out_valid = (state == ST_HOLD);
  assign take      = in_valid && in_ready;
  assign done      = out_valid && out_ready;
  assign hit_op    = take && state == ST_LEAD && in_byte == PFX_OPSZ;
  assign hit_ad    = take && state == ST_LEAD && in_byte == PFX_ADSZ;

  ixd_prefix_track u_pfx (
    .clk(clk), .rst_n(rst_n), .clr(done),
    .hit_op(hit_op), .hit_ad(hit_ad), .dflt_32(dflt_32),
    .op32_eff(op32_eff), .ad32_eff(ad32_eff)
  );

  ixd_disp_len u_len (
    .mod_f(in_byte[7:6]), .rm_f(in_byte[2:0]), .addr32(ad32_eff), .len(len_d)
  );

  ixd_disp_collect u_disp (
    .clk(clk), .rst_n(rst_n), .clr(done),
    .wr(take && state == ST_DISP), .lane(cnt), .byte_in(in_byte),
    .len(len_q), .disp(out_disp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_LEAD;
      cnt          <= '0;
      len_q        <= '0;
      out_opcode   <= '0;
      out_dir      <= 1'b0;
      out_wide     <= 1'b0;
      out_op_size  <= SZ_BYTE;
      out_addr32   <= 1'b0;
      out_reg_mode <= 1'b0;
      out_mod      <= '0;
      out_reg      <= '0;
      out_rm       <= '0;
    end else begin
      unique case (state)
        ST_LEAD: if (take && !hit_op && !hit_ad) begin
          out_opcode <= in_byte[7:2];
          out_dir    <= in_byte[1];
          out_wide   <= in_byte[0];
          state      <= ST_MODRM;
        end
        ST_MODRM: if (take) begin
          out_mod      <= in_byte[7:6];
          out_reg      <= in_byte[5:3];
          out_rm       <= in_byte[2:0];
          out_reg_mode <= (in_byte[7:6] == 2'b11);
          out_addr32   <= ad32_eff;
          out_op_size  <= !out_wide ? SZ_BYTE : (op32_eff ? SZ_DWORD : SZ_WORD);
          len_q        <= len_d;
          cnt          <= '0;
          state        <= (len_d == '0) ? ST_HOLD : ST_DISP;
        end
        ST_DISP: if (take) begin
          cnt <= cnt + 1'b1;
          if (LEN_W'(cnt) + LEN_W'(1) == len_q) state <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) begin
          state <= ST_LEAD;
          len_q <= '0;
        end
        default: state <= ST_LEAD;
      endcase
    end
  end
endmodule

// File: rtl/ixd_decoder_chk.sv
module ixd_decoder_chk
  import ixd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [5:0]        out_opcode,
  input logic              out_wide,
  input logic [1:0]        out_op_size,
  input logic              out_addr32,
  input logic              out_reg_mode,
  input logic [1:0]        out_mod,
  input logic [2:0]        out_rm,
  input logic [DISP_W-1:0] out_disp
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_disp) && $stable(out_opcode)
      && $stable(out_op_size) && $stable(out_mod));

  // R9
  no_take_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  handover_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  // R4
  byte_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wide |-> out_op_size == SZ_BYTE);

  // R5
  reg_mode_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg_mode |-> out_disp == '0 && out_mod == 2'b11);

  // R6
  mod0_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mod == 2'b00 && (out_addr32 || out_rm != 3'b110) |-> out_disp == '0);

  // R7
  mod1_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mod == 2'b01 |-> (out_disp[DISP_W-1:7] == '0 || out_disp[DISP_W-1:7] == '1));
endmodule

bind ixd_decoder ixd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_opcode(out_opcode), .out_wide(out_wide),
  .out_op_size(out_op_size), .out_addr32(out_addr32), .out_reg_mode(out_reg_mode),
  .out_mod(out_mod), .out_rm(out_rm), .out_disp(out_disp)
);

// File: tb/ixd_decoder_tb.sv
module ixd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dflt_32 = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_dir, out_wide, out_addr32, out_reg_mode;
  logic [5:0]  out_opcode;
  logic [1:0]  out_op_size, out_mod;
  logic [2:0]  out_reg, out_rm;
  logic [31:0] out_disp;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ixd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .dflt_32(dflt_32), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_opcode(out_opcode), .out_dir(out_dir),
    .out_wide(out_wide), .out_op_size(out_op_size), .out_addr32(out_addr32),
    .out_reg_mode(out_reg_mode), .out_mod(out_mod), .out_reg(out_reg),
    .out_rm(out_rm), .out_disp(out_disp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_rec(input string req, input logic [5:0] opc, input logic d,
                           input logic w, input logic [1:0] sz, input logic a32,
                           input logic [1:0] md, input logic [2:0] rg,
                           input logic [2:0] rm, input logic [31:0] disp);
    chk({req, " R11 valid after last byte"}, 32'(out_valid), 32'd1);
    chk({req, " R4 opcode"}, 32'(out_opcode), 32'(opc));
    chk({req, " R4 dir"}, 32'(out_dir), 32'(d));
    chk({req, " R4 size"}, 32'(out_op_size), 32'(sz));
    chk({req, " R4 wide"}, 32'(out_wide), 32'(w));
    chk({req, " R3 addr32"}, 32'(out_addr32), 32'(a32));
    chk({req, " R5 mod"}, 32'(out_mod), 32'(md));
    chk({req, " R5 regmode"}, 32'(out_reg_mode), 32'(md == 2'b11));
    chk({req, " R5 reg"}, 32'(out_reg), 32'(rg));
    chk({req, " R5 rm"}, 32'(out_rm), 32'(rm));
    chk({req, " disp"}, out_disp, disp);
  endtask

  task automatic release_rec(input string req);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk({req, " R10 valid drops"}, 32'(out_valid), 32'd0);
    chk({req, " R10 ready back"}, 32'(in_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_reg_mode();
    dflt_32 = 1'b0;
    send_byte(8'h8B);
    send_byte(8'hC3);
    check_rec("R5 regmode", 6'h22, 1, 1, 2'd1, 0, 2'b11, 3'd0, 3'd3, 32'h0);
    release_rec("R5");
  endtask

  task automatic t_prefix_toggle();
    dflt_32 = 1'b0;
    send_byte(8'h66);
    send_byte(8'h66);
    send_byte(8'h67);
    send_byte(8'h89);
    send_byte(8'h45);
    chk("R11 not valid before disp", 32'(out_valid), 32'd0);
    send_byte(8'hF0);
    check_rec("R2 R7 prefix", 6'h22, 0, 1, 2'd2, 1, 2'b01, 3'd0, 3'd5, 32'hFFFF_FFF0);
    release_rec("R2");
  endtask

  task automatic t_byte_w();
    dflt_32 = 1'b1;
    send_byte(8'h66);
    send_byte(8'h88);
    send_byte(8'h00);
    check_rec("R4 R6 byte", 6'h22, 0, 0, 2'd0, 1, 2'b00, 3'd0, 3'd0, 32'h0);
    release_rec("R4");
  endtask

  task automatic t_direct16();
    dflt_32 = 1'b0;
    send_byte(8'h8B);
    send_byte(8'h06);
    send_byte(8'h34);
    chk("R6 not valid after one disp byte", 32'(out_valid), 32'd0);
    send_byte(8'h12);
    check_rec("R6 direct16", 6'h22, 1, 1, 2'd1, 0, 2'b00, 3'd0, 3'd6, 32'h0000_1234);
    release_rec("R6");
  endtask

  task automatic t_disp32();
    dflt_32 = 1'b1;
    send_byte(8'h8B);
    send_byte(8'h85);
    send_byte(8'h78);
    send_byte(8'h56);
    send_byte(8'h34);
    chk("R8 not valid after three bytes", 32'(out_valid), 32'd0);
    send_byte(8'h12);
    check_rec("R8 disp32", 6'h22, 1, 1, 2'd2, 1, 2'b10, 3'd0, 3'd5, 32'h1234_5678);
    release_rec("R8");
  endtask

  task automatic t_disp16_neg();
    dflt_32 = 1'b0;
    send_byte(8'h8B);
    send_byte(8'h87);
    send_byte(8'h00);
    send_byte(8'h80);
    check_rec("R8 disp16 neg", 6'h22, 1, 1, 2'd1, 0, 2'b10, 3'd0, 3'd7, 32'hFFFF_8000);
    release_rec("R8b");
  endtask

  task automatic t_backpressure();
    dflt_32 = 1'b0;
    send_byte(8'h66);
    send_byte(8'h01);
    send_byte(8'hD8);
    check_rec("R9 rec", 6'h00, 0, 1, 2'd2, 0, 2'b11, 3'd3, 3'd0, 32'h0);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h66;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 held valid", 32'(out_valid), 32'd1);
      chk("R9 ready low", 32'(in_ready), 32'd0);
      chk("R9 op size held", 32'(out_op_size), 32'd2);
    end
    in_valid = 1'b0;
    release_rec("R9");
    send_byte(8'h8B);
    send_byte(8'hC1);
    check_rec("R10 prefix cleared", 6'h22, 1, 1, 2'd1, 0, 2'b11, 3'd0, 3'd1, 32'h0);
    release_rec("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_mode();
    t_prefix_toggle();
    t_byte_w();
    t_direct16();
    t_disp32();
    t_disp16_neg();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule